// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block drives the row and column shift registers built into a small active-matrix colour panel whose dots are laid out in a delta pattern. It uses two one-cycle strobes from the video timing chain, a line strobe and a field strobe, as its reference. From them it produces a clear pulse, a horizontal start and a two-phase horizontal shift clock for each line. It also produces a vertical start, a two-phase vertical shift clock and a gate-enable level that step the panel down its gate lines once per field.

Every line begins with a clear pulse. A fixed gap follows, then the horizontal start, then a burst of horizontal clock periods. On odd-numbered lines of the field the start and the burst move one and a half horizontal clock periods later, so that the samples line up with the shifted dot rows. A direction input exchanges the two horizontal phases to mirror the picture. A polarity flag flips on every line so that the video path can invert the drive line by line.

Top module: `panel_scan_gen`

## Requirements
- R1: Reset state: line_clr, h_start and v_start are 0, h_clk_a and v_clk_a are 0, h_clk_b and v_clk_b are 1, gate_en is 1, dir_level is 1 and vid_pol is 0.
- R2: line_clr goes high on the clock edge that samples hsync_stb and stays high for CLR_W cycles. A new hsync_stb during a line restarts the whole line sequence from that edge.
- R3: On an even line, h_start rises GAP_W cycles after line_clr falls and stays high for 2*HALF_DIV cycles. Lines are numbered 0 after a field strobe and 1 to LINES within the field; any line beyond LINES counts as even.
- R4: On an odd line (numbers 1, 3, ... up to LINES), h_start and the horizontal clock burst are delayed by a further 3*HALF_DIV cycles, which is one and a half horizontal clock periods.
- R5: With dir_ltr high, h_clk_a stays low for the first HALF_DIV cycles after h_start rises. It then runs HCK_PERIODS periods of HALF_DIV cycles high and HALF_DIV cycles low, and returns to low. h_clk_b is always the complement of h_clk_a.
- R6: dir_level is dir_ltr registered by one cycle. While it is low, h_clk_a and h_clk_b are exchanged, including their idle levels (h_clk_a idles high).
- R7: A field strobe sets the line number to 0 and puts v_clk_a low and v_clk_b high. Each line strobe that takes the line number from 0 up to LINES toggles both vertical phases on the edge that samples it. Later line strobes leave them unchanged until the next field strobe.
- R8: v_start rises MID_OFS cycles after the edge that samples the field strobe. It falls MID_OFS cycles after the line strobe that begins line 1, so it spans each vertical clock edge by about half a line on each side.
- R9: gate_en equals v_clk_a while the line number is between 1 and LINES, which makes it rise with the rise of phase A and fall with the rise of phase B. At all other times gate_en is held high.
- R10: vid_pol toggles on the edge that samples each line strobe. The field strobe does not change it.
- R11: When both strobes arrive in the same cycle, the field strobe sets the line number to 0 and the vertical phases do not toggle. The horizontal line still runs with even-line timing, and vid_pol still toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_stb | input | 1 | One-cycle line reference strobe |
| vsync_stb | input | 1 | One-cycle field reference strobe |
| dir_ltr | input | 1 | Horizontal scan direction, 1 = left to right |
| line_clr | output | 1 | Clear pulse at the start of each line |
| h_start | output | 1 | Horizontal shift register start |
| h_clk_a | output | 1 | Horizontal shift clock, phase A |
| h_clk_b | output | 1 | Horizontal shift clock, phase B |
| v_start | output | 1 | Vertical shift register start |
| v_clk_a | output | 1 | Vertical shift clock, phase A |
| v_clk_b | output | 1 | Vertical shift clock, phase B |
| gate_en | output | 1 | Gate-line enable |
| dir_level | output | 1 | Registered scan direction level |
| vid_pol | output | 1 | Per-line video polarity flag |

## Verification
The line strobe and the field strobe act on the same line counter, the same vertical phases and the same half-line timer, and they can arrive in the same clock cycle. The bench drives both in one cycle and then judges each output separately. The line number must go to 0 with no vertical edge, and v_start must rise half a line later. The clear pulse, start and clock burst must run with even-line timing, and the polarity flag must still flip. A second case fires a line strobe while the clear pulse of the previous line is still high; the clear must then stretch to its full width counted from the second strobe.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_CLR  = 2'd1,
    H_GAP  = 2'd2,
    H_RUN  = 2'd3
  } hline_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scan_h_seq.sv
module scan_h_seq
  import scan_pkg::*;
#(
  parameter int HALF_DIV    = 12,
  parameter int HCK_PERIODS = 271,
  parameter int CLR_W       = 231,
  parameter int GAP_W       = 129
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_stb,
  input  logic odd_line,
  input  logic dir_ltr,
  output logic clr_o,
  output logic hst_o,
  output logic hck_a_o,
  output logic hck_b_o,
  output logic dir_o
);

  localparam int OFS   = 3 * HALF_DIV;
  localparam int SPAN  = max2(CLR_W, GAP_W + OFS);
  localparam int CW    = $clog2(SPAN + 1);
  localparam int HW    = $clog2(HALF_DIV + 1);
  localparam int HALVES = 2 * HCK_PERIODS;
  localparam int RW    = $clog2(HALVES + 1);

  hline_state_t   st;
  logic [CW-1:0]  cnt;
  logic [HW-1:0]  hc;
  logic [RW-1:0]  run_half;
  logic           phase;
  logic           dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= H_IDLE;
      cnt      <= '0;
      hc       <= '0;
      run_half <= '0;
      phase    <= 1'b0;
      clr_o    <= 1'b0;
      hst_o    <= 1'b0;
      dir_q    <= 1'b1;
    end else begin
      dir_q <= dir_ltr;
      if (hsync_stb) begin
        st       <= H_CLR;
        cnt      <= CW'(CLR_W - 1);
        clr_o    <= 1'b1;
        hst_o    <= 1'b0;
        phase    <= 1'b0;
        run_half <= '0;
      end else begin
        unique case (st)
          H_IDLE: begin
            phase <= 1'b0;
          end
          H_CLR: begin
            if (cnt == '0) begin
              st    <= H_GAP;
              clr_o <= 1'b0;
              cnt   <= CW'(GAP_W - 1) + (odd_line ? CW'(OFS) : CW'(0));
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          H_GAP: begin
            if (cnt == '0) begin
              st       <= H_RUN;
              hst_o    <= 1'b1;
              hc       <= HW'(HALF_DIV - 1);
              run_half <= '0;
              phase    <= 1'b0;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          H_RUN: begin
            if (hc == '0) begin
              hc       <= HW'(HALF_DIV - 1);
              run_half <= run_half + 1'b1;
              if (run_half == RW'(1)) hst_o <= 1'b0;
              if (run_half == RW'(HALVES)) begin
                st    <= H_IDLE;
                phase <= 1'b0;
              end else begin
                phase <= ~phase;
              end
            end else begin
              hc <= hc - 1'b1;
            end
          end
          default: st <= H_IDLE;
        endcase
      end
    end
  end

  // Direction exchange of the two horizontal phases.
  assign hck_a_o = dir_q ? phase : ~phase;
  assign hck_b_o = dir_q ? ~phase : phase;
  assign dir_o   = dir_q;

  assert_clr_start_R2: assert property (@(posedge clk) disable iff (rst)
    hsync_stb |=> (clr_o && !hst_o));

  assert_hst_after_clr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_o) |-> (!clr_o && !$past(clr_o)));

  assert_start_phase_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_o) |-> (hck_a_o == !dir_q));

endmodule

// File: rtl/scan_v_seq.sv
module scan_v_seq #(
  parameter int LINES   = 225,
  parameter int MID_OFS = 2100
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_stb,
  input  logic vsync_stb,
  output logic vst_o,
  output logic vck_a_o,
  output logic vck_b_o,
  output logic gate_en_o,
  output logic odd_line_o
);

  localparam int LW = $clog2(LINES + 2);
  localparam int MW = $clog2(MID_OFS + 1);

  logic [LW-1:0] lcnt, lcnt_n;
  logic          vck_n;
  logic          in_field_n, in_field;
  logic [MW-1:0] mid_cnt;
  logic          mid_act;

  always_comb begin
    lcnt_n = lcnt;
    vck_n  = vck_a_o;
    if (vsync_stb) begin
      lcnt_n = '0;
      vck_n  = 1'b0;
    end else if (hsync_stb) begin
      if (lcnt < LW'(LINES)) begin
        lcnt_n = lcnt + 1'b1;
        vck_n  = ~vck_a_o;
      end else begin
        lcnt_n = LW'(LINES + 1);
      end
    end
    in_field_n = (lcnt_n != '0) && (lcnt_n <= LW'(LINES));
  end

  assign in_field   = (lcnt != '0) && (lcnt <= LW'(LINES));
  assign odd_line_o = lcnt[0] && in_field;

  always_ff @(posedge clk) begin
    if (rst) begin
      lcnt      <= LW'(LINES + 1);
      vck_a_o   <= 1'b0;
      vck_b_o   <= 1'b1;
      gate_en_o <= 1'b1;
      vst_o     <= 1'b0;
      mid_cnt   <= '0;
      mid_act   <= 1'b0;
    end else begin
      lcnt      <= lcnt_n;
      vck_a_o   <= vck_n;
      vck_b_o   <= ~vck_n;
      gate_en_o <= in_field_n ? vck_n : 1'b1;
      if (vsync_stb || hsync_stb) begin
        mid_act <= 1'b1;
        mid_cnt <= MW'(MID_OFS - 1);
      end else if (mid_act) begin
        if (mid_cnt == '0) begin
          mid_act <= 1'b0;
          vst_o   <= (lcnt == '0);
        end else begin
          mid_cnt <= mid_cnt - 1'b1;
        end
      end
    end
  end

  assert_vck_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (vck_a_o != $past(vck_a_o)) |-> ($past(hsync_stb) || $past(vsync_stb)));

  assert_vck_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    ((lcnt == LW'(LINES + 1)) && ($past(lcnt) == LW'(LINES + 1))) |-> $stable(vck_a_o));

  assert_en_idle_high_R9: assert property (@(posedge clk) disable iff (rst)
    !in_field |-> gate_en_o);

  assert_vst_line0_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(vst_o) |-> (lcnt == '0));

  assert_coincident_R11: assert property (@(posedge clk) disable iff (rst)
    (hsync_stb && vsync_stb) |=> (lcnt == '0 && !vck_a_o));

endmodule

// File: rtl/scan_line_pol.sv
module scan_line_pol (
  input  logic clk,
  input  logic rst,
  input  logic hsync_stb,
  output logic pol_o
);

  always_ff @(posedge clk) begin
    if (rst)            pol_o <= 1'b0;
    else if (hsync_stb) pol_o <= ~pol_o;
  end

  assert_pol_flip_R10: assert property (@(posedge clk) disable iff (rst)
    hsync_stb |=> (pol_o != $past(pol_o)));

endmodule

// File: rtl/panel_scan_gen.sv
module panel_scan_gen #(
  parameter int HALF_DIV    = 12,
  parameter int HCK_PERIODS = 271,
  parameter int CLR_W       = 231,
  parameter int GAP_W       = 129,
  parameter int LINES       = 225,
  parameter int MID_OFS     = 2100
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_stb,
  input  logic vsync_stb,
  input  logic dir_ltr,
  output logic line_clr,
  output logic h_start,
  output logic h_clk_a,
  output logic h_clk_b,
  output logic v_start,
  output logic v_clk_a,
  output logic v_clk_b,
  output logic gate_en,
  output logic dir_level,
  output logic vid_pol
);

  logic odd_line;

  scan_v_seq #(
    .LINES   (LINES),
    .MID_OFS (MID_OFS)
  ) u_vseq (
    .clk        (clk),
    .rst        (rst),
    .hsync_stb  (hsync_stb),
    .vsync_stb  (vsync_stb),
    .vst_o      (v_start),
    .vck_a_o    (v_clk_a),
    .vck_b_o    (v_clk_b),
    .gate_en_o  (gate_en),
    .odd_line_o (odd_line)
  );

  scan_h_seq #(
    .HALF_DIV    (HALF_DIV),
    .HCK_PERIODS (HCK_PERIODS),
    .CLR_W       (CLR_W),
    .GAP_W       (GAP_W)
  ) u_hseq (
    .clk       (clk),
    .rst       (rst),
    .hsync_stb (hsync_stb),
    .odd_line  (odd_line),
    .dir_ltr   (dir_ltr),
    .clr_o     (line_clr),
    .hst_o     (h_start),
    .hck_a_o   (h_clk_a),
    .hck_b_o   (h_clk_b),
    .dir_o     (dir_level)
  );

  scan_line_pol u_pol (
    .clk       (clk),
    .rst       (rst),
    .hsync_stb (hsync_stb),
    .pol_o     (vid_pol)
  );

endmodule

// File: tb/sim_panel_scan_gen.sv
module sim_panel_scan_gen;

  localparam int H     = 2;
  localparam int P     = 6;
  localparam int CLRW  = 5;
  localparam int GAPW  = 3;
  localparam int LINES = 5;
  localparam int MID   = 20;
  localparam int LCYC  = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_stb = 1'b0, vsync_stb = 1'b0, dir_ltr = 1'b1;
  logic line_clr, h_start, h_clk_a, h_clk_b, v_start, v_clk_a, v_clk_b;
  logic gate_en, dir_level, vid_pol;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int m_line = LINES + 1;
  bit m_vck = 0, m_vst = 0, m_pol = 0;

  always #4 clk = ~clk;

  panel_scan_gen #(
    .HALF_DIV(H), .HCK_PERIODS(P), .CLR_W(CLRW), .GAP_W(GAPW),
    .LINES(LINES), .MID_OFS(MID)
  ) u0 (
    .clk(clk), .rst(rst), .hsync_stb(hsync_stb), .vsync_stb(vsync_stb),
    .dir_ltr(dir_ltr), .line_clr(line_clr), .h_start(h_start),
    .h_clk_a(h_clk_a), .h_clk_b(h_clk_b), .v_start(v_start),
    .v_clk_a(v_clk_a), .v_clk_b(v_clk_b), .gate_en(gate_en),
    .dir_level(dir_level), .vid_pol(vid_pol)
  );

  task automatic check(input string req, input string sig, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, sig, $time, act, exp);
    end
  endtask

  task automatic model_strobe(input bit do_h, input bit do_v);
    if (do_v) begin
      m_line = 0;
      m_vck  = 0;
    end else if (do_h) begin
      if (m_line < LINES) begin
        m_line++;
        m_vck = !m_vck;
      end else begin
        m_line = LINES + 1;
      end
    end
    if (do_h) m_pol = !m_pol;
  endtask

  // One line window: strobes, then per-cycle comparison of every output.
  task automatic run_line(input bit do_h, input bit do_v, input string tag);
    bit odd;
    int t0;
    logic ph, ea, gx;
    model_strobe(do_h, do_v);
    odd = do_h && (m_line % 2 == 1) && (m_line <= LINES);
    t0  = CLRW + GAPW + (odd ? 3 * H : 0);
    @(negedge clk);
    hsync_stb = do_h;
    vsync_stb = do_v;
    @(negedge clk);
    hsync_stb = 0;
    vsync_stb = 0;
    for (int k = 0; k < LCYC; k++) begin
      if (k > 0) @(negedge clk);
      if (k == MID) m_vst = (m_line == 0);
      ph = 1'b0;
      if (do_h && k >= t0 + H && k < t0 + 2 * P * H) ph = (((k - t0) / H) % 2 == 1);
      ea = dir_ltr ? ph : !ph;
      gx = (m_line >= 1 && m_line <= LINES) ? m_vck : 1'b1;
      check((tag != "") ? tag : "R2", "line_clr", line_clr, do_h && k < CLRW);
      check((tag != "") ? tag : (odd ? "R4" : "R3"), "h_start", h_start,
            do_h && k >= t0 && k < t0 + 2 * H);
      check((tag != "") ? tag : (dir_ltr ? "R5" : "R6"), "h_clk_a", h_clk_a, ea);
      check((tag != "") ? tag : (dir_ltr ? "R5" : "R6"), "h_clk_b", h_clk_b, !ea);
      check((tag != "") ? tag : "R7", "v_clk_a", v_clk_a, m_vck);
      check((tag != "") ? tag : "R7", "v_clk_b", v_clk_b, !m_vck);
      check((tag != "") ? tag : "R8", "v_start", v_start, m_vst);
      check((tag != "") ? tag : "R9", "gate_en", gate_en, gx);
      check((tag != "") ? tag : "R10", "vid_pol", vid_pol, m_pol);
      check((tag != "") ? tag : "R6", "dir_level", dir_level, dir_ltr);
    end
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_line = LINES + 1; m_vck = 0; m_vst = 0; m_pol = 0;
    @(negedge clk);
    check("R1", "line_clr", line_clr, 1'b0);
    check("R1", "h_start", h_start, 1'b0);
    check("R1", "h_clk_a", h_clk_a, 1'b0);
    check("R1", "h_clk_b", h_clk_b, 1'b1);
    check("R1", "v_start", v_start, 1'b0);
    check("R1", "v_clk_a", v_clk_a, 1'b0);
    check("R1", "v_clk_b", v_clk_b, 1'b1);
    check("R1", "gate_en", gate_en, 1'b1);
    check("R1", "dir_level", dir_level, 1'b1);
    check("R1", "vid_pol", vid_pol, 1'b0);
  endtask

  // Full field left to right, including lines past LINES (R3 R4 R5 R7 R8 R9 R10).
  task automatic t_field_ltr();
    dir_ltr = 1;
    run_line(0, 1, "");
    for (int i = 0; i < LINES + 3; i++) run_line(1, 0, "");
  endtask

  // Reversed direction: phases exchanged (R6), field strobe alone leaves vid_pol (R10).
  task automatic t_field_rtl();
    dir_ltr = 0;
    run_line(0, 1, "");
    for (int i = 0; i < 3; i++) run_line(1, 0, "");
    dir_ltr = 1;
    run_line(1, 0, "");
  endtask

  // Both strobes in one cycle (R11), then the field continues normally.
  task automatic t_coincident();
    dir_ltr = 1;
    run_line(1, 1, "R11");
    for (int i = 0; i < 3; i++) run_line(1, 0, "");
  endtask

  // Second line strobe while the clear pulse is still high (R2).
  task automatic t_restart();
    model_strobe(1, 0);
    @(negedge clk);
    hsync_stb = 1;
    @(negedge clk);
    hsync_stb = 0;
    @(negedge clk);
    check("R2", "line_clr", line_clr, 1'b1);
    run_line(1, 0, "");
  endtask

  // Field strobe in the middle of a field restarts the vertical sequence (R7).
  task automatic t_midfield_vsync();
    run_line(1, 0, "");
    run_line(0, 1, "");
    for (int i = 0; i < 2; i++) run_line(1, 0, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_field_ltr();
    t_field_rtl();
    t_coincident();
    t_restart();
    t_midfield_vsync();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

endmodule